// File: doc/BRIEF.md
# Configurable Pixel Format Packer

This streaming block takes one pixel per clock as four 8-bit channels (red, green, blue, alpha). It converts each pixel to a selected output layout and packs the results into 32-bit memory words. A 4-bit format code selects both the channel order and the pixel width. The widths are 16 bits (4444 or 565), 24 bits (888) and 32 bits (8888). Channels are reduced by keeping their most significant bits. Alpha can be stored as it is, stored inverted, or replaced by a constant fill.

Packing is little-endian. The first pixel's bytes go into the lowest lanes, and 24-bit pixels may straddle two words. An end-of-line marker on a pixel flushes any partial word, with the unused lanes disabled. A 4-bit lane mask gates the byte enables of every emitted word. Format codes outside the defined set discard the pixel and raise an error pulse. The format, alpha controls and lane mask are expected to stay constant within a line.

Top module: `pxp_packer`

## Requirements
- R1: Format codes are 0 ABGR4444, 1 ARGB4444, 2 BGRA4444, 3 RGBA4444, 6 BGR565, 7 RGB565, 8 BGR888, 9 RGB888, 12 ABGR8888, 13 ARGB8888, 14 BGRA8888 and 15 RGBA8888. Each name lists fields from the most significant bit of the pixel down to the least. Narrow fields take the top bits of their channel.
- R2: With `alpha_keep` high, the alpha field holds the alpha input XOR-ed with `alpha_flip` on every bit. With `alpha_keep` low, every bit of the alpha field equals the inverse of `alpha_flip`.
- R3: 16-bit formats place two pixels per word, with the earlier pixel in bits 15:0.
- R4: 888 formats emit pixel bytes least significant first into consecutive lanes. Four pixels fill exactly three words, and a pixel may span two words.
- R5: A word appears on `word_data` with `word_valid` high in the cycle after the edge that sampled the pixel completing it. Every accepted 8888 pixel yields a valid word in the next cycle.
- R6: A full word's `word_be` equals `lane_mask`. Bit i of `word_be` refers to bits 8i+7:8i.
- R7: A pixel with `pix_eol` high is always followed by a valid word in the next cycle. If that pixel leaves a partial word, the partial word is emitted zero-padded, with `word_be` limited to the occupied low lanes and ANDed with `lane_mask`. The next line then starts at lane 0.
- R8: If an end-of-line pixel both completes a word and leaves bytes over, the full word is emitted first and the leftover partial word in the following cycle. Any word produced in that following cycle is delayed by one cycle, and no word is lost.
- R9: A pixel with format code 4, 5, 10 or 11 is discarded and does not change the packing state. `fmt_err` is high for exactly the cycle after it.
- R10: After reset, and in every cycle without a word, `word_valid`, `word_be` and `fmt_err` are low. Reset discards any partial word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_eol | input | 1 | Pixel is last of its line |
| pix_r | input | 8 | Red channel |
| pix_g | input | 8 | Green channel |
| pix_b | input | 8 | Blue channel |
| pix_a | input | 8 | Alpha channel |
| fmt_sel | input | 4 | Output format code |
| alpha_keep | input | 1 | Store alpha (1) or fill it (0) |
| alpha_flip | input | 1 | Invert stored alpha / choose fill value |
| lane_mask | input | 4 | Byte-lane enable mask |
| word_valid | output | 1 | Packed word present |
| word_data | output | 32 | Packed word |
| word_be | output | 4 | Byte enables of the word |
| fmt_err | output | 1 | Pulse after a pixel with an undefined code |

## Verification
In an 888 line, two events can land in the same cycle: completing a full word and flushing the leftover bytes at end of line. This happens when the end-of-line pixel is the second or third of a four-pixel group. The bench provokes this with a line of two RGB888 pixels under a non-trivial lane mask. It then presents an 8888 pixel in the very next cycle, so that the held partial word and a freshly completed word compete for the output. It expects three consecutive results: the full word, the zero-padded two-byte partial with its enables masked, and the delayed 8888 word.

// File: rtl/pxp_pkg.sv
package pxp_pkg;
  localparam int unsigned CH_W       = 8;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned WORD_W     = 8 * WORD_BYTES;
  localparam int unsigned FMT_W      = 4;

  // Pixel width class, taken from the upper two code bits
  typedef enum logic [1:0] {
    CLS_4444 = 2'b00,
    CLS_565  = 2'b01,
    CLS_888  = 2'b10,
    CLS_8888 = 2'b11
  } pix_class_e;

  function automatic logic code_defined(input logic [FMT_W-1:0] code);
    case (code)
      4'd4, 4'd5, 4'd10, 4'd11: code_defined = 1'b0;
      default:                  code_defined = 1'b1;
    endcase
  endfunction

  function automatic logic [2:0] code_bytes(input logic [FMT_W-1:0] code);
    case (pix_class_e'(code[3:2]))
      CLS_4444, CLS_565: code_bytes = 3'd2;
      CLS_888:           code_bytes = 3'd3;
      default:           code_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/pxp_fmt_decode.sv
module pxp_fmt_decode
  import pxp_pkg::*;
(
  input  logic [FMT_W-1:0] code,
  output logic             legal,
  output logic [2:0]       nbytes
);
  always_comb begin
    legal  = code_defined(code);
    nbytes = legal ? code_bytes(code) : 3'd0;
  end
endmodule

// File: rtl/pxp_pixel_pack.sv
module pxp_pixel_pack
  import pxp_pkg::*;
(
  input  logic [CH_W-1:0]   ch_r,
  input  logic [CH_W-1:0]   ch_g,
  input  logic [CH_W-1:0]   ch_b,
  input  logic [CH_W-1:0]   ch_a,
  input  logic [FMT_W-1:0]  code,
  input  logic              keep_a,
  input  logic              flip_a,
  output logic [WORD_W-1:0] bits
);
  logic [CH_W-1:0] a_eff;

  always_comb begin
    a_eff = keep_a ? (ch_a ^ {CH_W{flip_a}}) : {CH_W{~flip_a}};
    bits  = '0;
    case (pix_class_e'(code[3:2]))
      CLS_4444: begin
        case (code[1:0])
          2'd0: bits[15:0] = {a_eff[7:4], ch_b[7:4], ch_g[7:4], ch_r[7:4]};
          2'd1: bits[15:0] = {a_eff[7:4], ch_r[7:4], ch_g[7:4], ch_b[7:4]};
          2'd2: bits[15:0] = {ch_b[7:4], ch_g[7:4], ch_r[7:4], a_eff[7:4]};
          default: bits[15:0] = {ch_r[7:4], ch_g[7:4], ch_b[7:4], a_eff[7:4]};
        endcase
      end
      CLS_565: begin
        if (code[0]) bits[15:0] = {ch_r[7:3], ch_g[7:2], ch_b[7:3]};
        else         bits[15:0] = {ch_b[7:3], ch_g[7:2], ch_r[7:3]};
      end
      CLS_888: begin
        if (code[0]) bits[23:0] = {ch_r, ch_g, ch_b};
        else         bits[23:0] = {ch_b, ch_g, ch_r};
      end
      default: begin
        case (code[1:0])
          2'd0: bits = {a_eff, ch_b, ch_g, ch_r};
          2'd1: bits = {a_eff, ch_r, ch_g, ch_b};
          2'd2: bits = {ch_b, ch_g, ch_r, a_eff};
          default: bits = {ch_r, ch_g, ch_b, a_eff};
        endcase
      end
    endcase
  end
endmodule

// File: rtl/pxp_word_accum.sv
module pxp_word_accum #(
  parameter int unsigned WB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic          in_eol,
  input  logic [2:0]    in_bytes,
  input  logic [8*WB-1:0] in_data,
  input  logic [WB-1:0] lane_mask,
  output logic          out_vld,
  output logic [8*WB-1:0] out_data,
  output logic [WB-1:0] out_be
);
  localparam int unsigned CNT_W = $clog2(WB);
  localparam int unsigned ACC_W = 8 * (WB - 1);
  localparam int unsigned MRG_W = 8 * (2 * WB - 1);
  localparam int unsigned DW    = 8 * WB;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_vld_q, pend_vld_d;
  logic [DW-1:0]    pend_data_q, pend_data_d;
  logic [WB-1:0]    pend_be_q, pend_be_d;
  logic             out_vld_d;
  logic [DW-1:0]    out_data_d;
  logic [WB-1:0]    out_be_d;

  logic [MRG_W-1:0] merged;
  logic [2:0]       total, rem;
  logic             full;
  logic [ACC_W-1:0] rem_data;
  logic [WB-1:0]    rem_lanes;
  logic             cur_vld, spill_vld;
  logic [DW-1:0]    cur_data, spill_data;
  logic [WB-1:0]    cur_be, spill_be;

  // Lanes occupied by the leftover bytes
  for (genvar gi = 0; gi < WB; gi++) begin : g_lane
    assign rem_lanes[gi] = (3'(gi) < rem);
  end

  always_comb begin
    merged   = ({{(MRG_W-DW){1'b0}}, in_data} << {cnt_q, 3'b000})
             | {{(MRG_W-ACC_W){1'b0}}, acc_q};
    total    = {1'b0, cnt_q} + in_bytes;
    full     = (total >= 3'(WB));
    rem      = full ? (total - 3'(WB)) : total;
    rem_data = full ? merged[MRG_W-1:DW] : merged[ACC_W-1:0];

    acc_d      = acc_q;
    cnt_d      = cnt_q;
    cur_vld    = 1'b0;
    cur_data   = '0;
    cur_be     = '0;
    spill_vld  = 1'b0;
    spill_data = '0;
    spill_be   = '0;

    if (in_vld) begin
      if (full) begin
        cur_vld  = 1'b1;
        cur_data = merged[DW-1:0];
        cur_be   = lane_mask;
        if (in_eol && rem != 3'd0) begin
          spill_vld  = 1'b1;
          spill_data = {8'h00, rem_data};
          spill_be   = lane_mask & rem_lanes;
        end
      end else if (in_eol) begin
        cur_vld  = 1'b1;
        cur_data = {8'h00, rem_data};
        cur_be   = lane_mask & rem_lanes;
      end
      if (in_eol) begin
        acc_d = '0;
        cnt_d = '0;
      end else begin
        acc_d = rem_data;
        cnt_d = rem[CNT_W-1:0];
      end
    end

    // One-deep hold for a leftover word: it wins the output, any new word waits
    if (pend_vld_q) begin
      out_vld_d   = 1'b1;
      out_data_d  = pend_data_q;
      out_be_d    = pend_be_q;
      pend_vld_d  = cur_vld | spill_vld;
      pend_data_d = cur_vld ? cur_data : spill_data;
      pend_be_d   = cur_vld ? cur_be : spill_be;
    end else begin
      out_vld_d   = cur_vld;
      out_data_d  = cur_data;
      out_be_d    = cur_be;
      pend_vld_d  = spill_vld;
      pend_data_d = spill_data;
      pend_be_d   = spill_be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (in_vld) begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld_q  <= 1'b0;
      pend_data_q <= '0;
      pend_be_q   <= '0;
      out_vld     <= 1'b0;
      out_data    <= '0;
      out_be      <= '0;
    end else begin
      pend_vld_q  <= pend_vld_d;
      pend_data_q <= pend_data_d;
      pend_be_q   <= pend_be_d;
      out_vld     <= out_vld_d;
      out_data    <= out_data_d;
      out_be      <= out_be_d;
    end
  end
endmodule

// File: rtl/pxp_packer.sv
module pxp_packer
  import pxp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic              pix_eol,
  input  logic [CH_W-1:0]   pix_r,
  input  logic [CH_W-1:0]   pix_g,
  input  logic [CH_W-1:0]   pix_b,
  input  logic [CH_W-1:0]   pix_a,
  input  logic [FMT_W-1:0]  fmt_sel,
  input  logic              alpha_keep,
  input  logic              alpha_flip,
  input  logic [WORD_BYTES-1:0] lane_mask,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  output logic [WORD_BYTES-1:0] word_be,
  output logic              fmt_err
);
  logic              legal;
  logic [2:0]        nbytes;
  logic [WORD_W-1:0] pix_bits;
  logic              take;
  logic              err_d;

  pxp_fmt_decode u_dec (
    .code   (fmt_sel),
    .legal  (legal),
    .nbytes (nbytes)
  );

  pxp_pixel_pack u_pack (
    .ch_r   (pix_r),
    .ch_g   (pix_g),
    .ch_b   (pix_b),
    .ch_a   (pix_a),
    .code   (fmt_sel),
    .keep_a (alpha_keep),
    .flip_a (alpha_flip),
    .bits   (pix_bits)
  );

  always_comb begin
    take  = pix_valid & legal;
    err_d = pix_valid & ~legal;
  end

  pxp_word_accum #(.WB(WORD_BYTES)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld    (take),
    .in_eol    (pix_eol),
    .in_bytes  (nbytes),
    .in_data   (pix_bits),
    .lane_mask (lane_mask),
    .out_vld   (word_valid),
    .out_data  (word_data),
    .out_be    (word_be)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fmt_err <= 1'b0;
    else        fmt_err <= err_d;
  end
endmodule

// File: rtl/pxp_packer_chk.sv
module pxp_packer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pix_valid,
  input logic       pix_eol,
  input logic [3:0] fmt_sel,
  input logic       word_valid,
  input logic [3:0] word_be,
  input logic       fmt_err
);
  logic bad_code;
  assign bad_code = (fmt_sel == 4'd4) || (fmt_sel == 4'd5) ||
                    (fmt_sel == 4'd10) || (fmt_sel == 4'd11);

  assert_err_after_bad_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && bad_code) |=> fmt_err);

  assert_err_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |-> $past(pix_valid && bad_code));

  assert_word_after_wide_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && fmt_sel[3:2] == 2'b11) |=> word_valid);

  assert_eol_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_eol && !bad_code) |=> word_valid);

  assert_be_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> (word_be == 4'b0000));
endmodule

bind pxp_packer pxp_packer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pix_valid  (pix_valid),
  .pix_eol    (pix_eol),
  .fmt_sel    (fmt_sel),
  .word_valid (word_valid),
  .word_be    (word_be),
  .fmt_err    (fmt_err)
);

// File: tb/pxp_packer_bench.sv
`timescale 1ns/1ps
module pxp_packer_bench;
  logic        clk;
  logic        rst_n;
  logic        pix_valid, pix_eol;
  logic [7:0]  pix_r, pix_g, pix_b, pix_a;
  logic [3:0]  fmt_sel;
  logic        alpha_keep, alpha_flip;
  logic [3:0]  lane_mask;
  logic        word_valid;
  logic [31:0] word_data;
  logic [3:0]  word_be;
  logic        fmt_err;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  pxp_packer u_pxp_packer (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_eol(pix_eol),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .pix_a(pix_a),
    .fmt_sel(fmt_sel), .alpha_keep(alpha_keep), .alpha_flip(alpha_flip),
    .lane_mask(lane_mask), .word_valid(word_valid), .word_data(word_data),
    .word_be(word_be), .fmt_err(fmt_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // fmt, keep, flip, mask, r, g, b, a, eol | exp valid, data, be, err
  localparam int NV = 11;
  localparam logic [80:0] VEC [NV] = '{
    {4'd13,1'b1,1'b0,4'hf,8'h12,8'h34,8'h56,8'h78,1'b0, 1'b1,32'h78123456,4'hf,1'b0}, // R1 R2 R5
    {4'd12,1'b1,1'b1,4'hf,8'h12,8'h34,8'h56,8'h78,1'b0, 1'b1,32'h87563412,4'hf,1'b0}, // R2 inverted alpha
    {4'd14,1'b0,1'b0,4'hf,8'h12,8'h34,8'h56,8'h78,1'b0, 1'b1,32'h563412ff,4'hf,1'b0}, // R2 fill ones
    {4'd15,1'b0,1'b1,4'h5,8'h12,8'h34,8'h56,8'h78,1'b0, 1'b1,32'h12345600,4'h5,1'b0}, // R2 fill zeros, R6
    {4'd7, 1'b0,1'b0,4'hf,8'hff,8'h00,8'hff,8'h00,1'b0, 1'b0,32'h0,4'h0,1'b0},        // R3 first half
    {4'd7, 1'b0,1'b0,4'hf,8'h00,8'hff,8'h00,8'h00,1'b0, 1'b1,32'h07e0f81f,4'hf,1'b0}, // R3
    {4'd3, 1'b1,1'b0,4'hf,8'ha0,8'hb0,8'hc0,8'hd0,1'b1, 1'b1,32'h0000abcd,4'h3,1'b0}, // R7 R1
    {4'd0, 1'b0,1'b0,4'hf,8'h10,8'h20,8'h30,8'h99,1'b0, 1'b0,32'h0,4'h0,1'b0},        // R1 R2
    {4'd1, 1'b1,1'b1,4'hf,8'h60,8'h70,8'h80,8'h50,1'b0, 1'b1,32'ha678f321,4'hf,1'b0}, // R1 R3
    {4'd6, 1'b0,1'b0,4'hf,8'h00,8'h00,8'hff,8'h00,1'b1, 1'b1,32'h0000f800,4'h3,1'b0}, // R1 R7
    {4'd4, 1'b1,1'b0,4'hf,8'h11,8'h22,8'h33,8'h44,1'b0, 1'b0,32'h0,4'h0,1'b1}         // R9
  };
  localparam int VREQ [NV] = '{5, 2, 2, 6, 3, 3, 7, 1, 1, 7, 9};

  task automatic drive(input logic [3:0] f, input logic k, input logic fl,
                       input logic [3:0] m, input logic [7:0] r, input logic [7:0] g,
                       input logic [7:0] b, input logic [7:0] a,
                       input logic v, input logic e);
    fmt_sel = f; alpha_keep = k; alpha_flip = fl; lane_mask = m;
    pix_r = r; pix_g = g; pix_b = b; pix_a = a; pix_valid = v; pix_eol = e;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string req, input logic ev, input logic [31:0] ed,
                            input logic [3:0] ebe, input logic eerr);
    checks++;
    if (word_valid !== ev || word_be !== ebe || fmt_err !== eerr ||
        (ev && word_data !== ed)) begin
      errors++;
      $display("FAIL %s: valid=%b data=%h be=%h err=%b expected valid=%b data=%h be=%h err=%b",
               req, word_valid, word_data, word_be, fmt_err, ev, ed, ebe, eerr);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    pix_valid = 0; pix_eol = 0; pix_r = 0; pix_g = 0; pix_b = 0; pix_a = 0;
    fmt_sel = 4'd13; alpha_keep = 0; alpha_flip = 0; lane_mask = 4'hf;
    repeat (3) @(posedge clk);
    #1;
    expect_out("R10 reset", 1'b0, 32'h0, 4'h0, 1'b0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][80:77], VEC[i][76], VEC[i][75], VEC[i][74:71], VEC[i][70:63],
            VEC[i][62:55], VEC[i][54:47], VEC[i][46:39], 1'b1, VEC[i][38]);
      expect_out($sformatf("R%0d vector %0d", VREQ[i], i),
                 VEC[i][37], VEC[i][36:5], VEC[i][4:1], VEC[i][0]);
    end
    drive(4'd13, 0, 0, 4'hf, 0, 0, 0, 0, 1'b0, 1'b0);
    expect_out("R10 idle", 1'b0, 32'h0, 4'h0, 1'b0);

    // R4: four RGB888 pixels fill three words
    drive(4'd9, 0, 0, 4'hf, 8'h01, 8'h02, 8'h03, 8'h00, 1'b1, 1'b0);
    expect_out("R4 p0", 1'b0, 32'h0, 4'h0, 1'b0);
    drive(4'd9, 0, 0, 4'hf, 8'h04, 8'h05, 8'h06, 8'h00, 1'b1, 1'b0);
    expect_out("R4 p1", 1'b1, 32'h06010203, 4'hf, 1'b0);
    drive(4'd9, 0, 0, 4'hf, 8'h07, 8'h08, 8'h09, 8'h00, 1'b1, 1'b0);
    expect_out("R4 p2", 1'b1, 32'h08090405, 4'hf, 1'b0);
    drive(4'd9, 0, 0, 4'hf, 8'h0a, 8'h0b, 8'h0c, 8'h00, 1'b1, 1'b0);
    expect_out("R4 p3", 1'b1, 32'h0a0b0c07, 4'hf, 1'b0);

    // R1 R7: single BGR888 pixel at end of line
    drive(4'd8, 0, 0, 4'hf, 8'h01, 8'h02, 8'h03, 8'h00, 1'b1, 1'b1);
    expect_out("R7 bgr888 flush", 1'b1, 32'h00030201, 4'h7, 1'b0);

    // R8: end of line completes a word and leaves two bytes; 8888 pixel follows
    drive(4'd9, 0, 0, 4'he, 8'h01, 8'h02, 8'h03, 8'h00, 1'b1, 1'b0);
    expect_out("R8 lead", 1'b0, 32'h0, 4'h0, 1'b0);
    drive(4'd9, 0, 0, 4'he, 8'h04, 8'h05, 8'h06, 8'h00, 1'b1, 1'b1);
    expect_out("R8 full word", 1'b1, 32'h06010203, 4'he, 1'b0);
    drive(4'd13, 1, 0, 4'he, 8'h11, 8'h22, 8'h33, 8'h44, 1'b1, 1'b0);
    expect_out("R8 spill word", 1'b1, 32'h00000405, 4'h2, 1'b0);
    drive(4'd13, 1, 0, 4'he, 0, 0, 0, 0, 1'b0, 1'b0);
    expect_out("R8 delayed word", 1'b1, 32'h44112233, 4'he, 1'b0);
    drive(4'd13, 1, 0, 4'hf, 0, 0, 0, 0, 1'b0, 1'b0);
    expect_out("R10 drained", 1'b0, 32'h0, 4'h0, 1'b0);

    // R9: undefined code leaves the half-filled word untouched
    drive(4'd7, 0, 0, 4'hf, 8'hff, 8'hff, 8'hff, 8'h00, 1'b1, 1'b0);
    expect_out("R9 first half", 1'b0, 32'h0, 4'h0, 1'b0);
    drive(4'd10, 0, 0, 4'hf, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1);
    expect_out("R9 bad code", 1'b0, 32'h0, 4'h0, 1'b1);
    drive(4'd7, 0, 0, 4'hf, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0);
    expect_out("R9 state kept", 1'b1, 32'h0000ffff, 4'hf, 1'b0);

    // R10: reset discards a partial word
    drive(4'd7, 0, 0, 4'hf, 8'hff, 8'hff, 8'hff, 8'h00, 1'b1, 1'b0);
    pix_valid = 1'b0;
    rst_n = 1'b0;
    #2;
    expect_out("R10 async reset", 1'b0, 32'h0, 4'h0, 1'b0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    drive(4'd7, 0, 0, 4'hf, 8'h00, 8'hff, 8'h00, 8'h00, 1'b1, 1'b1);
    expect_out("R10 fresh line", 1'b1, 32'h000007e0, 4'h3, 1'b0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule